// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Bank

This block holds sixteen 32-bit doorbell words that let the four cores of a cluster signal one another. Every core owns a group of four words. Any bus master can raise bits in a word by writing to its set address, or lower bits by writing to its clear address. No address replaces a whole word. Each word drives one level interrupt toward its owning core. That line stays high while any bit of the word is one. Masking, interrupt class selection and routing are left to a separate interrupt router.

A typical use: a core rings another core by writing a message bit into word 0 of the target group. The target reads the word and then writes the same bits to the clear address, which acknowledges the message. During bring-up, a boot core writes a start address into word 3 of a sleeping core's group. That core waits until the word becomes nonzero, then jumps to the address.

The register interface is single-cycle and synchronous. A write takes effect at the clock edge where write enable is high. Read data is combinational and shows the stored contents of the addressed word.

Top module: `doorbell_bank`

## Requirements
- R1: After reset, all sixteen words read as zero and all sixteen interrupt outputs are low.
- R2: A write to byte offset 0x80 + 16·c + 4·m ORs the write data into word 4·c + m, for core c in 0..3 and word m in 0..3.
- R3: A write to byte offset 0xC0 + 16·c + 4·m clears, in word 4·c + m, each bit that is one in the write data, and leaves the other bits unchanged.
- R4: Interrupt output bit k is high in every cycle where word k is nonzero, and low in every cycle where word k is zero. An output therefore changes in the cycle after the write that changed its word.
- R5: A read at either the set offset or the clear offset of word k returns the current contents of word k, in the same cycle.
- R6: When write enable is low, the address and the write data have no effect on any word.
- R7: A write changes only the addressed word. The other fifteen words keep their values.
- R8: A write to an offset below 0x80 has no effect on any word. A read at such an offset returns zero.
- R9: Address bits [1:0] are ignored. For example, offset 0x81 accesses the same word as 0x80.
- R10: Writing all-zero data to a set offset or to a clear offset leaves that word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data, used as a bit mask |
| bus_rdata | output | 32 | Contents of the addressed word, or zero outside the apertures |
| irq_out | output | 16 | One level interrupt per word; bit k belongs to word k |

## Verification
Partial set masks followed by partial clear masks on one word show whether the block ORs and AND-NOTs the data, or overwrites the word. Writing all-ones and then clearing all-ones tells the level interrupt apart from an edge or a pulse. After each directed write, all sixteen words are read back at both apertures. This catches writes that land on a neighbouring word and any mix-up of core and word index. Random traffic over the whole 8-bit address space then mixes these cases with:
- idle cycles,
- stray writes below 0x80,
- misaligned addresses.

Each result is compared with a model of the bank kept in the bench.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    // Which aperture an access falls into
    typedef enum logic [1:0] {
        AP_NONE = 2'd0,
        AP_SET  = 2'd1,
        AP_CLR  = 2'd2
    } aperture_e;

    // Bytes between neighbouring words
    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
    import doorbell_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_BOX  = 16,
    parameter int unsigned SET_BASE = 'h80,
    parameter int unsigned CLR_BASE = 'hC0,
    localparam int unsigned IDX_W   = $clog2(NUM_BOX)
) (
    input  logic [ADDR_W-1:0] addr,
    output aperture_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W:0]   SPAN   = (ADDR_W+1)'(NUM_BOX * WORD_BYTES);
    localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(SET_BASE);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_BASE);

    logic [ADDR_W-1:0] off_set;
    logic [ADDR_W-1:0] off_clr;
    logic              in_set;
    logic              in_clr;

    always_comb begin
        off_set = addr - SET_A;
        off_clr = addr - CLR_A;
        in_set  = (addr >= SET_A) && ({1'b0, off_set} < SPAN);
        in_clr  = (addr >= CLR_A) && ({1'b0, off_clr} < SPAN);
        kind    = AP_NONE;
        idx     = '0;
        if (in_set) begin
            kind = AP_SET;
            idx  = off_set[IDX_W+1:2];
        end else if (in_clr) begin
            kind = AP_CLR;
            idx  = off_clr[IDX_W+1:2];
        end
    end

endmodule

// File: rtl/doorbell_slot.sv
module doorbell_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] nxt,
    output logic              busy
);

    // Bits named in both masks end up set
    always_comb begin
        nxt  = (cur & ~clr_mask) | set_mask;
        busy = |cur;
    end

endmodule

// File: rtl/doorbell_bank.sv
module doorbell_bank
    import doorbell_pkg::*;
#(
    parameter int unsigned NUM_CORES     = 4,
    parameter int unsigned BOX_PER_CORE  = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned SET_BASE      = 'h80,
    parameter int unsigned CLR_BASE      = 'hC0,
    localparam int unsigned NUM_BOX      = NUM_CORES * BOX_PER_CORE,
    localparam int unsigned IDX_W        = $clog2(NUM_BOX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_BOX-1:0]  irq_out
);

    typedef struct packed {
        logic [NUM_BOX-1:0][DATA_W-1:0] box;
    } bank_t;

    bank_t state_d;
    bank_t state_q;

    aperture_e             acc_kind;
    logic [IDX_W-1:0]      acc_idx;
    logic [NUM_BOX-1:0]    hit_onehot;

    logic [NUM_BOX-1:0][DATA_W-1:0] set_mask;
    logic [NUM_BOX-1:0][DATA_W-1:0] clr_mask;
    logic [NUM_BOX-1:0][DATA_W-1:0] box_nxt;
    logic [NUM_BOX-1:0]             box_busy;

    doorbell_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BOX  (NUM_BOX),
        .SET_BASE (SET_BASE),
        .CLR_BASE (CLR_BASE)
    ) decode_i (
        .addr (bus_addr),
        .kind (acc_kind),
        .idx  (acc_idx)
    );

    always_comb begin
        hit_onehot = '0;
        if (bus_we && acc_kind != AP_NONE) begin
            hit_onehot[acc_idx] = 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_BOX; k++) begin : g_slot
        always_comb begin
            set_mask[k] = (hit_onehot[k] && acc_kind == AP_SET) ? bus_wdata : '0;
            clr_mask[k] = (hit_onehot[k] && acc_kind == AP_CLR) ? bus_wdata : '0;
        end

        doorbell_slot #(
            .DATA_W (DATA_W)
        ) slot_i (
            .cur      (state_q.box[k]),
            .set_mask (set_mask[k]),
            .clr_mask (clr_mask[k]),
            .nxt      (box_nxt[k]),
            .busy     (box_busy[k])
        );

        // A nonzero set write raises this word's line on the next cycle
        AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && acc_kind == AP_SET && acc_idx == IDX_W'(k) && bus_wdata != '0)
            |=> irq_out[k]);  // R2

        // A clear of every bit drops the line on the next cycle
        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && acc_kind == AP_CLR && acc_idx == IDX_W'(k) && (&bus_wdata))
            |=> !irq_out[k]);  // R3
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        for (int k = 0; k < NUM_BOX; k++) begin
            state_d.box[k] = box_nxt[k];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_out   = box_busy;
        bus_rdata = (acc_kind != AP_NONE) ? state_q.box[acc_idx] : '0;
    end

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(irq_out));  // R6

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && acc_kind == AP_NONE) |=> $stable(irq_out));  // R8

    AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (((irq_out ^ $past(irq_out)) & ~$past(hit_onehot)) == '0));  // R7

endmodule

// File: tb/doorbell_bank_tb_top.sv
module doorbell_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_box [16];

    always #5 clk = ~clk;

    doorbell_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a >= 8'h80) return exp_box[a[5:2]];
        return 32'h0;
    endfunction

    function automatic void model_wr(logic [7:0] a, logic [31:0] d);
        if (a >= 8'hC0)      exp_box[a[5:2]] = exp_box[a[5:2]] & ~d;
        else if (a >= 8'h80) exp_box[a[5:2]] = exp_box[a[5:2]] | d;
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [15:0] v;
        for (int k = 0; k < 16; k++) v[k] = (exp_box[k] != 32'h0);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(logic we, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        if (we) model_wr(a, d);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    // Read back every word at both apertures and compare interrupts (R5, R7)
    task automatic full_chk(string req);
        for (int k = 0; k < 16; k++) begin
            rd_chk(req, 8'(8'h80 + k*4));
            rd_chk(req, 8'(8'hC0 + k*4));
        end
        chk({req, " irq R4"}, {16'h0, irq_out}, {16'h0, exp_irq()});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 16; k++) exp_box[k] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq", {16'h0, irq_out}, 32'h0);
        full_chk("R1");

        // R2/R5: start address into word 3 of core 0
        op(1'b1, 8'h8C, 32'h1234_5678);
        rd_chk("R5 set aperture", 8'h8C);
        rd_chk("R5 clr aperture", 8'hCC);
        chk("R4 irq3 high", {31'h0, irq_out[3]}, 32'h1);
        op(1'b1, 8'h8C, 32'h8000_0001);
        chk("R2 or-merge", exp_box[3], 32'h9234_5679);
        full_chk("R2 R7");

        // R3: partial then full clear of word 3
        op(1'b1, 8'hCC, 32'h0000_FFFF);
        rd_chk("R3 partial clear", 8'hCC);
        chk("R4 irq still high", {31'h0, irq_out[3]}, 32'h1);
        op(1'b1, 8'hCC, 32'hFFFF_0000);
        chk("R4 irq low when zero", {31'h0, irq_out[3]}, 32'h0);
        full_chk("R3");

        // core 2 word 1 and core 3 word 0
        op(1'b1, 8'hA4, 32'hA5A5_0000);
        op(1'b1, 8'hB0, 32'h0000_0100);
        full_chk("R2 index");

        // R6: write enable low
        op(1'b0, 8'hA4, 32'hFFFF_FFFF);
        op(1'b0, 8'hE4, 32'hFFFF_FFFF);
        full_chk("R6");

        // R8: below the apertures
        op(1'b1, 8'h40, 32'hFFFF_FFFF);
        op(1'b1, 8'h7C, 32'hFFFF_FFFF);
        rd_chk("R8 read zero", 8'h7C);
        rd_chk("R8 read zero low", 8'h00);
        full_chk("R8");

        // R9: misaligned addresses
        op(1'b1, 8'h81, 32'h0000_00F0);
        chk("R9 set misaligned", exp_box[0], 32'h0000_00F0);
        rd_chk("R9 read misaligned", 8'hC3);
        op(1'b1, 8'hC2, 32'h0000_0030);
        full_chk("R9");

        // R10: zero data
        op(1'b1, 8'hA4, 32'h0);
        op(1'b1, 8'hE4, 32'h0);
        full_chk("R10");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        we;
            a  = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 3) != 0) a[7] = 1'b1;
            d  = $urandom();
            if ($urandom_range(0, 2) == 0) d = d & $urandom();
            we = ($urandom_range(0, 4) != 0);
            op(we, a, d);
            chk("R4 random irq", {16'h0, irq_out}, {16'h0, exp_irq()});
            rd_chk("R5 random read", 8'($urandom_range(0, 255)));
        end
        full_chk("R7 final");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule